// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 128K words by 16 bits. A client presents a word address, a read/write flag, 16 bits of write data and a two-bit lane mask under a valid/ready handshake. The controller takes the request, holds it, and runs the RAM strobes (chip select, output enable, write enable and one select per byte lane, all active low) through a fixed sequence of phases. Each phase lasts a whole number of system clocks. That number is worked out at elaboration from nanosecond minima and the clock-period parameter.

A read returns the selected lanes on `rd_data` with a one-cycle `rd_valid` pulse. Lanes that the mask leaves out read as zero. A write first holds output enable high long enough for the RAM's output drivers to release the shared bus. Only then does the controller enable its own drivers and pulse write enable. Only the lanes set in the mask are written.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rd_valid` is low, `sram_dq_drive` is low, and every RAM strobe (`sram_ce_n`, `sram_oe_n`, `sram_we_n`, both `sram_lane_n` bits) is high.
- R2: `req_ready` is low from the clock edge that accepts a request until the operation completes. Address, data, mask and direction are captured at acceptance, so changes to the request inputs after that edge have no effect on the operation.
- R3: During a read, `sram_ce_n` and `sram_oe_n` are low and `sram_we_n` is high for ceil(70 ns / clock period) cycles, which is 14 cycles at 5 ns. Lane select bit 0 (data bits 7:0) is low when mask bit 0 is 1, and lane select bit 1 (data bits 15:8) is low when mask bit 1 is 1.
- R4: Read data is sampled on the first clock edge at or after the access time. `rd_valid` is a one-cycle pulse in the cycle after that edge, and `req_ready` is high in the same cycle. Lanes whose mask bit is 0 return zero in `rd_data`.
- R5: A write opens with a setup phase of at least ceil(30 ns / clock period) cycles. In this phase chip select is low, output enable and write enable are high, and the data bus is not driven.
- R6: The write-enable low pulse lasts at least 55 ns. Write data is driven for at least 40 ns before write enable rises. Chip select is low for at least 60 ns before write enable rises, and write enable is never low while chip select is high.
- R7: After write enable rises, the write data stays driven and chip select stays low for one more cycle. After that the bus is released.
- R8: The controller never drives the data bus while output enable is low, or within 30 ns after output enable rises, including a write issued straight after a read.
- R9: A write changes only the lanes whose mask bit is 1. The other byte of the stored word keeps its value.
- R10: A request with mask 00 completes normally. A write with mask 00 leaves memory unchanged, and a read with mask 00 returns zero with a `rd_valid` pulse.
- R11: The captured address is presented on `sram_addr` for the whole operation, across the full 17-bit range up to 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 17 | RAM address lines |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_lane_n | output | 2 | RAM byte-lane selects, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data toward the RAM |
| sram_dq_drive | output | 1 | Enable for the controller's bus drivers |
| sram_dq_in | input | 16 | Data from the RAM pins |

## Verification
The bench builds the controller with its default values: a 5 ns clock period, the 70/55/60/40/30 ns minima, and a 17-bit by 16-bit geometry. With these values the phase lengths come to 14 read cycles, 6 setup cycles and 11 pulse cycles. The bench's RAM model returns valid data only 69 ns after output enable falls, so a read phase that is one cycle short returns filler bytes. The full address width lets a write and readback at 0x1FFFF exercise the top address bit. The model also stamps strobe and driver edges in nanoseconds, so pulse width, data setup and bus turnaround are checked against the real minima rather than against cycle counts.

// File: rtl/sram_ctl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing figures are integer nanoseconds.
package sram_ctl_pkg;

    // Operation phase; the strobes are decoded from this value
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_WSU,
        PH_WPL,
        PH_WHD
    } phase_e;

    // Whole cycles needed to cover a span given in ns
    function automatic int ns_cycles(input int span_ns, input int clk_ns);
        return (span_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_req_reg.sv
// Request holding register: captures the client's request on acceptance
// and keeps it steady for the whole RAM operation.
// Assumes take is only high while the controller is idle.
module sram_req_reg #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_mask,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata,
    output logic [LANES-1:0]  hold_mask
);

    // Load every field on acceptance, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_mask  <= '0;
        end else if (take) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
            hold_mask  <= in_mask;
        end
    end

endmodule

// File: rtl/sram_seq.sv
// Phase sequencer: steps idle -> read access, or idle -> write setup ->
// write pulse -> write hold, with every phase lasting a parameter count
// of cycles. Assumes every count is at least 1.
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 14,
    parameter int SU_CYC = 6,
    parameter int PW_CYC = 11
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  logic   go_wr,
    output phase_e phase,
    output logic   last
);

    localparam int MAXC  = imax(RD_CYC, imax(SU_CYC, PW_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_m1;

    // Final count value of the current phase
    always_comb begin
        case (phase)
            PH_RD:   len_m1 = CNT_W'(RD_CYC - 1);
            PH_WSU:  len_m1 = CNT_W'(SU_CYC - 1);
            PH_WPL:  len_m1 = CNT_W'(PW_CYC - 1);
            default: len_m1 = '0;
        endcase
        last = (cnt == len_m1);
    end

    // Phase register and in-phase cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (go) phase <= go_wr ? PH_WSU : PH_RD;
                end
                PH_RD: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_IDLE;
                end
                PH_WSU: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_WPL;
                end
                PH_WPL: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_WHD;
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // R2
    seq_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && go) |=> (phase != PH_IDLE));

    // R7
    seq_hold_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WPL && last) |=> (phase == PH_WHD));

endmodule

// File: rtl/sram_pin_drv.sv
// Pin driver: decodes the RAM strobes and bus direction from the phase,
// and captures the masked read data at the end of the access phase.
// Assumes DATA_W is a whole number of bytes and LANES = DATA_W / 8.
module sram_pin_drv
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              last,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic [LANES-1:0]  hold_mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              active;
    logic [DATA_W-1:0] keep_bits;

    // Strobe and bus-direction decode
    always_comb begin
        active   = (phase != PH_IDLE);
        ce_n     = ~active;
        oe_n     = ~(phase == PH_RD);
        we_n     = ~(phase == PH_WPL);
        dq_drive = (phase == PH_WPL) || (phase == PH_WHD);
        ram_addr = hold_addr;
        dq_out   = hold_wdata;
    end

    // One select and one read-data mask byte per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g]          = ~(active & hold_mask[g]);
        assign keep_bits[g*8 +: 8] = {8{hold_mask[g]}};
    end

    // Capture read data on the last access cycle and pulse valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (phase == PH_RD && last) begin
            rd_valid <= 1'b1;
            rd_data  <= dq_in & keep_bits;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R8
    drive_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> oe_n);

    // R4
    rd_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    we_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

endmodule

// File: rtl/sram_byte_ctrl.sv
// Top of the byte-lane SRAM controller: valid/ready request port in,
// asynchronous SRAM strobes and split data bus out. Phase lengths are
// derived here from ns minima and CLK_NS.
// Assumes an external pad drives the RAM pins from sram_dq_out when
// sram_dq_drive is high.
module sram_byte_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS  = 5,
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int T_AA_NS = 70,
    parameter int T_RC_NS = 70,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_CW_NS = 60,
    parameter int T_DW_NS = 40,
    parameter int T_HZ_NS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [1:0]        sram_lane_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_drive,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int LANES  = DATA_W / 8;
    localparam int RD_CYC = imax(ns_cycles(T_AA_NS, CLK_NS), ns_cycles(T_RC_NS, CLK_NS));
    localparam int PW_MIN = imax(ns_cycles(T_WP_NS, CLK_NS), ns_cycles(T_DW_NS, CLK_NS));
    localparam int SU_CYC = imax(imax(1, ns_cycles(T_HZ_NS, CLK_NS)),
                                 ns_cycles(T_CW_NS, CLK_NS) - PW_MIN);
    localparam int PW_CYC = imax(PW_MIN, ns_cycles(T_WC_NS, CLK_NS) - SU_CYC - 1);
    localparam int WCNT_W = $clog2(PW_CYC + 2);

    phase_e            phase;
    logic              last;
    logic              take;
    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic [LANES-1:0]  hold_mask;

    assign req_ready = (phase == PH_IDLE);
    assign take      = req_valid & req_ready;

    sram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_req (
        .clk(clk), .rst_n(rst_n), .take(take),
        .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
        .in_mask(req_mask[LANES-1:0]),
        .hold_write(hold_write), .hold_addr(hold_addr),
        .hold_wdata(hold_wdata), .hold_mask(hold_mask)
    );

    sram_seq #(.RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .PW_CYC(PW_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(take), .go_wr(req_write),
        .phase(phase), .last(last)
    );

    sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pin (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(last),
        .hold_addr(hold_addr), .hold_wdata(hold_wdata), .hold_mask(hold_mask),
        .dq_in(sram_dq_in), .ram_addr(sram_addr),
        .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
        .lane_n(sram_lane_n), .dq_out(sram_dq_out), .dq_drive(sram_dq_drive),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Cycles write enable has been low, for the pulse-width check
    logic [WCNT_W-1:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_cnt <= '0;
        else if (!sram_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else                 we_low_cnt <= '0;
    end

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_ready);

    // R6
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= WCNT_W'(PW_CYC)));

    // R11
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R5
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && hold_write) |-> sram_oe_n);

endmodule

// File: tb/sim_sram_byte_ctrl.sv
`timescale 1ns/1ps
module sim_sram_byte_ctrl;

    localparam int RD_CYC = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [1:0]  sram_lane_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_drive;
    logic [15:0] sram_dq_in;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sram_byte_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_lane_n(sram_lane_n),
        .sram_dq_out(sram_dq_out), .sram_dq_drive(sram_dq_drive),
        .sram_dq_in(sram_dq_in)
    );

    // RAM model: sparse storage, data valid 69 ns after output enable falls
    logic [15:0] mem [int];
    logic        ram_ok = 1'b0;
    logic [15:0] word;
    real t_we_fall = 0, t_ce_fall = 0, t_drv_rise = 0, t_oe_rise = -1000;
    real pulse_ns = 0, ce_span_ns = 0, setup_ns = 0, turn_ns = 1000;
    bit  hold_ok = 1'b0;
    int  contention = 0;

    always @(negedge sram_oe_n) begin
        ram_ok = 1'b0;
        #69;
        ram_ok = !sram_oe_n;
    end
    always @(posedge sram_oe_n) begin
        ram_ok    = 1'b0;
        t_oe_rise = $realtime;
    end
    always @* begin
        word = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
        sram_dq_in[7:0]  = (ram_ok && !sram_ce_n && !sram_lane_n[0]) ? word[7:0]  : 8'hA5;
        sram_dq_in[15:8] = (ram_ok && !sram_ce_n && !sram_lane_n[1]) ? word[15:8] : 8'h5A;
    end
    always @(negedge sram_ce_n) t_ce_fall = $realtime;
    always @(negedge sram_we_n) t_we_fall = $realtime;
    always @(posedge sram_dq_drive) begin
        t_drv_rise = $realtime;
        turn_ns    = $realtime - t_oe_rise;
        if (turn_ns < 30.0) contention++;
    end
    always @(negedge clk) if (sram_dq_drive && !sram_oe_n) contention++;
    always @(posedge sram_we_n) begin
        if (rst_n && !sram_ce_n) begin
            pulse_ns   = $realtime - t_we_fall;
            ce_span_ns = $realtime - t_ce_fall;
            setup_ns   = $realtime - t_drv_rise;
            word = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
            if (!sram_lane_n[0]) word[7:0]  = sram_dq_out[7:0];
            if (!sram_lane_n[1]) word[15:8] = sram_dq_out[15:8];
            mem[int'(sram_addr)] = word;
            #1;
            hold_ok = sram_dq_drive && !sram_ce_n;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request; returns after the accepting edge
    task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rd_valid && !sram_dq_drive, "R1 idle outputs",
              {req_ready, rd_valid, sram_dq_drive}, 3'b100);
        check(sram_ce_n && sram_oe_n && sram_we_n && sram_lane_n == 2'b11,
              "R1 strobes high", {sram_ce_n, sram_oe_n, sram_we_n, sram_lane_n}, 5'h1f);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        int n;
        issue(1'b1, a, d, m);
        @(negedge clk);
        check(!sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_drive, "R5 setup phase",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_drive}, 4'b0110);
        check(!req_ready, "R2 busy during write", req_ready, 0);
        check(sram_addr == a, "R11 address presented", sram_addr, a);
        n = 1;
        while (!req_ready && n < 60) begin @(negedge clk); n++; end
        check(n == 19, "R7 write length incl hold", n, 19);
        check(pulse_ns >= 55.0, "R6 we pulse ns", int'(pulse_ns), 55);
        check(setup_ns >= 40.0, "R6 data setup ns", int'(setup_ns), 40);
        check(ce_span_ns >= 60.0, "R6 ce before we rise ns", int'(ce_span_ns), 60);
        check(hold_ok, "R7 data held after we rise", hold_ok, 1);
        check(!sram_dq_drive, "R7 bus released", sram_dq_drive, 0);
    endtask

    task automatic t_read(input logic [16:0] a, input logic [1:0] m,
                          input logic [15:0] exp, input string tag);
        int n;
        issue(1'b0, a, 16'h0, m);
        @(negedge clk);
        check(!sram_ce_n && !sram_oe_n && sram_we_n && sram_lane_n == ~m,
              "R3 read strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_lane_n},
              {3'b001, ~m});
        check(sram_addr == a, "R11 read address", sram_addr, a);
        n = 1;
        while (!rd_valid && n < 60) begin @(negedge clk); n++; end
        check(n == RD_CYC + 1, "R4 read latency", n, RD_CYC + 1);
        check(rd_data == exp, tag, rd_data, exp);
        check(req_ready, "R4 ready with valid", req_ready, 1);
        @(negedge clk);
        check(!rd_valid, "R4 valid one cycle", rd_valid, 0);
    endtask

    task automatic t_lanes();
        t_write(17'h00010, 16'hBEEF, 2'b11);
        t_read(17'h00010, 2'b11, 16'hBEEF, "R4 full word readback");
        t_write(17'h00010, 16'h1234, 2'b01);
        t_read(17'h00010, 2'b11, 16'hBE34, "R9 low lane write only");
        t_read(17'h00010, 2'b10, 16'hBE00, "R4 low lane masked to zero");
        t_read(17'h00010, 2'b01, 16'h0034, "R4 high lane masked to zero");
    endtask

    task automatic t_top_addr();
        t_write(17'h1FFFF, 16'hABCD, 2'b10);
        t_read(17'h1FFFF, 2'b11, 16'hAB00, "R11 R9 top address upper lane");
        t_read(17'h0FFFF, 2'b11, 16'h0000, "R11 alias below top untouched");
    endtask

    task automatic t_latch();
        issue(1'b1, 17'h00100, 16'h5555, 2'b11);
        req_addr = 17'h00200; req_wdata = 16'hAAAA; req_mask = 2'b00; req_write = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        check(!req_ready, "R2 ready low while busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        t_read(17'h00100, 2'b11, 16'h5555, "R2 latched data written");
        t_read(17'h00200, 2'b11, 16'h0000, "R2 late address ignored");
    endtask

    task automatic t_empty_mask();
        t_write(17'h00010, 16'h0000, 2'b00);
        t_read(17'h00010, 2'b11, 16'hBE34, "R10 empty write no effect");
        t_read(17'h00010, 2'b00, 16'h0000, "R10 empty read zero");
    endtask

    task automatic t_turnaround();
        contention = 0;
        t_read(17'h00010, 2'b11, 16'hBE34, "R8 read before write");
        t_write(17'h00020, 16'h7E57, 2'b11);
        check(turn_ns >= 30.0, "R8 oe rise to drive ns", int'(turn_ns), 30);
        check(contention == 0, "R8 no bus contention", contention, 0);
        t_read(17'h00020, 2'b11, 16'h7E57, "R8 write after read stored");
    endtask

    initial begin
        t_reset();
        t_lanes();
        t_top_addr();
        t_latch();
        t_empty_mask();
        t_turnaround();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: run hung actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule